// File: doc/BRIEF.md
# Microprogram Engine Launch and Status Controller

This block is the host-side control point of a microprogrammed processing engine. It holds three launch registers (a microprogram start address, a data pointer to a parameter block in memory, and a transfer-control word) and a status word with four live fields: a run flag, a completion flag, an interrupt enable and a soft-reset strobe. A host launches an operation in three steps. It loads the start address with the wanted entry point, which is a word offset of 0 to 3 from the microprogram base: coefficient load, horizontal scaling, vertical scaling, or horizontal scaling with colour conversion and overlay. It then loads the data pointer. Last, it writes the run flag to 1.

The rising edge of the run flag does two things. It enables the sequencer clock, and it sends a one-cycle request to the fetch unit for the first block of microinstructions at the current start address. The engine reports completion through two single-cycle inputs, one that drops the run flag and one that raises the completion flag. The completion flag ANDed with the enable drives a level interrupt, which stays high until the host acknowledges it. The host can also raise the completion flag itself, or stop the engine and pulse a soft reset.

Top module: `ulc_top`

## Requirements
- R1: An active-low hardware reset clears the status word, the start address, the data pointer and the transfer-control word to 0. While reset is held, `seq_clk_en`, `fetch_req`, `soft_rst` and `irq` are 0.
- R2: The registers sit at byte offsets 0x0 (status), 0x4 (start address), 0x8 (data pointer) and 0xC (transfer control). `host_waddr` is the offset divided by 4. A write stores the low bits of `host_wdata` that fit the register. `host_rdata` combinationally returns the register selected by `host_waddr`, zero-extended.
- R3: Status bits are: bit 0 run, bit 1 done, bit 2 interrupt enable, bit 3 acknowledge, bit 4 soft reset. A status read returns run, done and enable in bits 0 to 2, and 0 in all other bits.
- R4: In the first cycle after the run flag goes from 0 to 1, `fetch_req` is 1 for exactly one cycle and `fetch_addr` equals the start address. A write of 1 while the flag is already 1 makes no request.
- R5: `seq_clk_en` follows the run flag: it is 1 from the cycle after the flag is set and 0 from the cycle after the flag is cleared by either side.
- R6: While the run flag is 1, writes to the start address and the data pointer are ignored. The transfer-control word stays writable.
- R7: An `eng_clr_busy` pulse clears the run flag and an `eng_set_done` pulse sets the completion flag. When `eng_clr_busy` arrives in the same cycle as a host status write, the engine wins if the flag was already 1; if the flag was 0, the host's written value is taken.
- R8: `irq` is the completion flag ANDed with the enable and is held as a level. With `IRQ_REG`=1 it lags both by one cycle; with `IRQ_REG`=0 it has no lag.
- R9: Writing 1 to the acknowledge bit clears the completion flag. A status write with acknowledge 0 and done 0 leaves the completion flag unchanged.
- R10: An `eng_set_done` in the same cycle as an acknowledge write leaves the completion flag set.
- R11: A host status write with done = 1 sets the completion flag, which forces the interrupt when it is enabled.
- R12: A status write with run = 0 and soft reset = 1 clears the run flag and gives a one-cycle `soft_rst` pulse in the next cycle. With run = 1 in the same write, no pulse is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| host_wr | input | 1 | Host write strobe |
| host_waddr | input | 2 | Register word index (byte offset / 4) |
| host_wdata | input | HOST_DW | Host write data |
| host_rdata | output | HOST_DW | Read data of the selected register |
| eng_clr_busy | input | 1 | Engine pulse: clear run flag |
| eng_set_done | input | 1 | Engine pulse: set completion flag |
| seq_clk_en | output | 1 | Sequencer clock enable |
| fetch_req | output | 1 | One-cycle request for the first microinstruction block |
| fetch_addr | output | PTR_W | Start address for the fetch |
| soft_rst | output | 1 | One-cycle soft reset to the sequencer |
| irq | output | 1 | Level interrupt |
| dptr | output | PTR_W | Parameter block pointer to the engine |
| xfer_ctl | output | XCTL_W | Transfer-control word to the engine |

## Verification
The bench builds the block with PTR_W = 24, XCTL_W = 12 and IRQ_REG = 1. This keeps 32-bit host writes wider than the pointer and control registers, so both truncation on write and zero-extension on read are checked. It also selects the registered interrupt path, so the one-cycle interrupt lag is measured at the port. The combinational interrupt variant and full-width registers are reached only through elaboration with the default parameters. Same-cycle collisions are driven on purpose: engine clear against a host start, and engine completion against an acknowledge.

// File: rtl/ulc_pkg.sv
`timescale 1ns/1ps
package ulc_pkg;
   // status word bit positions (host visible encoding)
   localparam int ST_BUSY = 0;
   localparam int ST_DONE = 1;
   localparam int ST_IE   = 2;
   localparam int ST_ACK  = 3;
   localparam int ST_SRST = 4;
   localparam int ST_W    = 5;

   typedef enum logic [1:0] {
      RSEL_STATUS = 2'd0,
      RSEL_UPC    = 2'd1,
      RSEL_DPTR   = 2'd2,
      RSEL_XCTL   = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic ie;
      logic done;
      logic busy;
   } status_t;
endpackage

// File: rtl/ulc_host_regs.sv
`timescale 1ns/1ps
module ulc_host_regs
   import ulc_pkg::*;
#(
   parameter int PTR_W   = 32,
   parameter int XCTL_W  = 16,
   parameter int HOST_DW = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  reg_sel_e           sel,
   input  logic [HOST_DW-1:0] wdata,
   input  logic               busy,
   output logic [PTR_W-1:0]   upc,
   output logic [PTR_W-1:0]   dptr,
   output logic [XCTL_W-1:0]  xctl
);
   logic wr_upc, wr_dptr, wr_xctl;

   // launch pointers are frozen while the engine runs
   assign wr_upc  = wr_en && (sel == RSEL_UPC)  && !busy;
   assign wr_dptr = wr_en && (sel == RSEL_DPTR) && !busy;
   assign wr_xctl = wr_en && (sel == RSEL_XCTL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upc  <= '0;
         dptr <= '0;
         xctl <= '0;
      end else begin
         if (wr_upc)  upc  <= wdata[PTR_W-1:0];
         if (wr_dptr) dptr <= wdata[PTR_W-1:0];
         if (wr_xctl) xctl <= wdata[XCTL_W-1:0];
      end
   end

   AST_UPC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(upc)); // R6
   AST_DPTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(dptr)); // R6
endmodule

// File: rtl/ulc_status.sv
`timescale 1ns/1ps
module ulc_status
   import ulc_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_status,
   input  logic [ST_W-1:0] wbits,
   input  logic          eng_clr_busy,
   input  logic          eng_set_done,
   output status_t       st,
   output logic          soft_rst
);
   status_t st_n;
   logic    srst_n;

   always_comb begin
      st_n = st;
      // run flag: engine clear beats a host write only once already running
      if (wr_status)
         st_n.busy = wbits[ST_BUSY] & ~(eng_clr_busy & st.busy);
      else if (eng_clr_busy)
         st_n.busy = 1'b0;
      // completion flag: any set beats an acknowledge
      if (eng_set_done)
         st_n.done = 1'b1;
      else if (wr_status && wbits[ST_DONE])
         st_n.done = 1'b1;
      else if (wr_status && wbits[ST_ACK])
         st_n.done = 1'b0;
      if (wr_status)
         st_n.ie = wbits[ST_IE];
      srst_n = wr_status & wbits[ST_SRST] & ~wbits[ST_BUSY];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= '0;
         soft_rst <= 1'b0;
      end else begin
         st       <= st_n;
         soft_rst <= srst_n;
      end
   end

   AST_ENG_CLR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (st.busy && eng_clr_busy) |=> !st.busy); // R7
   AST_ENG_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      eng_set_done |=> st.done); // R10
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_status && wbits[ST_ACK] && !wbits[ST_DONE] && !eng_set_done) |=> !st.done); // R9
   AST_SRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |-> !st.busy); // R12
   AST_SRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!soft_rst || $past(wr_status))); // R12
endmodule

// File: rtl/ulc_launch.sv
`timescale 1ns/1ps
module ulc_launch #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   input  logic done,
   input  logic ie,
   output logic seq_clk_en,
   output logic fetch_req,
   output logic irq
);
   logic busy_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_d <= 1'b0;
      else        busy_d <= busy;
   end

   assign seq_clk_en = busy;
   assign fetch_req  = busy & ~busy_d;

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= done & ie;
         end
         assign irq = irq_q;
         AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            (done && ie) |=> irq); // R8
         AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            !(done && ie) |=> !irq); // R8
      end else begin : g_irq_comb
         assign irq = done & ie;
      end
   endgenerate

   AST_FETCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |=> !fetch_req); // R4
   AST_FETCH_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && seq_clk_en) |=> (!fetch_req || !$past(busy) || !busy)); // R4
endmodule

// File: rtl/ulc_top.sv
`timescale 1ns/1ps
module ulc_top
   import ulc_pkg::*;
#(
   parameter int PTR_W   = 32,
   parameter int XCTL_W  = 16,
   parameter int HOST_DW = 32,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_wr,
   input  logic [1:0]         host_waddr,
   input  logic [HOST_DW-1:0] host_wdata,
   output logic [HOST_DW-1:0] host_rdata,
   input  logic               eng_clr_busy,
   input  logic               eng_set_done,
   output logic               seq_clk_en,
   output logic               fetch_req,
   output logic [PTR_W-1:0]   fetch_addr,
   output logic               soft_rst,
   output logic               irq,
   output logic [PTR_W-1:0]   dptr,
   output logic [XCTL_W-1:0]  xfer_ctl
);
   localparam int STAT_PAD = HOST_DW - 3;

   generate
      if (PTR_W < 1 || PTR_W > HOST_DW) begin : g_bad_ptr
         $error("ulc_top: PTR_W must be 1..HOST_DW");
      end
      if (XCTL_W < 1 || XCTL_W > HOST_DW) begin : g_bad_xctl
         $error("ulc_top: XCTL_W must be 1..HOST_DW");
      end
      if (HOST_DW < ST_W) begin : g_bad_dw
         $error("ulc_top: HOST_DW too narrow for the status word");
      end
   endgenerate

   reg_sel_e          sel;
   status_t           st;
   logic [PTR_W-1:0]  upc;

   assign sel = reg_sel_e'(host_waddr);

   ulc_host_regs #(
      .PTR_W  (PTR_W),
      .XCTL_W (XCTL_W),
      .HOST_DW(HOST_DW)
   ) u_regs (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_en(host_wr),
      .sel  (sel),
      .wdata(host_wdata),
      .busy (st.busy),
      .upc  (upc),
      .dptr (dptr),
      .xctl (xfer_ctl)
   );

   ulc_status u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_status   (host_wr && (sel == RSEL_STATUS)),
      .wbits       (host_wdata[ST_W-1:0]),
      .eng_clr_busy(eng_clr_busy),
      .eng_set_done(eng_set_done),
      .st          (st),
      .soft_rst    (soft_rst)
   );

   ulc_launch #(
      .IRQ_REG(IRQ_REG)
   ) u_launch (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy      (st.busy),
      .done      (st.done),
      .ie        (st.ie),
      .seq_clk_en(seq_clk_en),
      .fetch_req (fetch_req),
      .irq       (irq)
   );

   assign fetch_addr = upc;

   always_comb begin
      unique case (sel)
         RSEL_STATUS: host_rdata = {{STAT_PAD{1'b0}}, st.ie, st.done, st.busy};
         RSEL_UPC:    host_rdata = HOST_DW'(upc);
         RSEL_DPTR:   host_rdata = HOST_DW'(dptr);
         default:     host_rdata = HOST_DW'(xfer_ctl);
      endcase
   end

   AST_FETCH_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && seq_clk_en) |=> $stable(fetch_addr)); // R4
endmodule

// File: tb/ulc_top_test.sv
`timescale 1ns/1ps
module ulc_top_test;
   localparam int PTR_W = 24;
   localparam int XCTL_W = 12;
   localparam int HOST_DW = 32;

   localparam int SEL_RDATA = 0, SEL_FETCH = 1, SEL_FADDR = 2, SEL_CLKEN = 3,
                  SEL_IRQ = 4, SEL_SRST = 5, SEL_DPTR = 6, SEL_XCTL = 7;

   typedef struct {
      string       req;
      int          sel;
      logic [31:0] exp;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_wr = 1'b0;
   logic [1:0] host_waddr = 2'd0;
   logic [HOST_DW-1:0] host_wdata = '0;
   logic [HOST_DW-1:0] host_rdata;
   logic eng_clr_busy = 1'b0;
   logic eng_set_done = 1'b0;
   logic seq_clk_en, fetch_req, soft_rst, irq;
   logic [PTR_W-1:0] fetch_addr, dptr;
   logic [XCTL_W-1:0] xfer_ctl;

   int n_run = 0;
   int n_fail = 0;
   item_t q[$];
   event sample_ev;

   always #2 clk = ~clk;

   ulc_top #(.PTR_W(PTR_W), .XCTL_W(XCTL_W), .HOST_DW(HOST_DW), .IRQ_REG(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_waddr(host_waddr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .eng_clr_busy(eng_clr_busy), .eng_set_done(eng_set_done),
      .seq_clk_en(seq_clk_en), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
      .soft_rst(soft_rst), .irq(irq), .dptr(dptr), .xfer_ctl(xfer_ctl)
   );

   function automatic logic [31:0] observe(int s);
      case (s)
         SEL_RDATA: return host_rdata;
         SEL_FETCH: return {31'd0, fetch_req};
         SEL_FADDR: return 32'(fetch_addr);
         SEL_CLKEN: return {31'd0, seq_clk_en};
         SEL_IRQ:   return {31'd0, irq};
         SEL_SRST:  return {31'd0, soft_rst};
         SEL_DPTR:  return 32'(dptr);
         default:   return 32'(xfer_ctl);
      endcase
   endfunction

   // monitor: pops expected items and compares with the ports
   initial begin
      forever begin
         @(sample_ev);
         while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            act = observe(it.sel);
            n_run++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s sel=%0d actual=0x%0h expected=0x%0h", it.req, it.sel, act, it.exp);
            end
         end
      end
   end

   task automatic push(input string req, input int s, input logic [31:0] e);
      item_t it;
      it.req = req; it.sel = s; it.exp = e;
      q.push_back(it);
   endtask

   task automatic fire();
      -> sample_ev;
      #0.5;
   endtask

   // one clock cycle of stimulus; returns 1 ns after the active edge
   task automatic cyc(input bit w, input logic [1:0] a, input logic [31:0] d,
                      input bit clr, input bit setd);
      @(negedge clk);
      host_wr = w; host_waddr = a; host_wdata = d;
      eng_clr_busy = clr; eng_set_done = setd;
      @(posedge clk); #1;
      host_wr = 1'b0; eng_clr_busy = 1'b0; eng_set_done = 1'b0;
   endtask

   task automatic idle();
      cyc(1'b0, host_waddr, 32'd0, 1'b0, 1'b0);
   endtask

   task automatic rd(input logic [1:0] a, input logic [31:0] e, input string req);
      host_waddr = a;
      #0.5;
      push(req, SEL_RDATA, e);
      fire();
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      // R1 reset state
      repeat (3) @(posedge clk);
      #1;
      rd(2'd0, 32'd0, "R1 status at reset");
      push("R1 clk_en at reset", SEL_CLKEN, 0);
      push("R1 irq at reset", SEL_IRQ, 0);
      push("R1 fetch at reset", SEL_FETCH, 0);
      push("R1 soft_rst at reset", SEL_SRST, 0);
      fire();
      @(negedge clk); rst_n = 1'b1;

      // R2 register load, truncation and zero-extension
      cyc(1'b1, 2'd1, 32'hFF12_3402, 1'b0, 1'b0);
      cyc(1'b1, 2'd2, 32'h00AB_CDE0, 1'b0, 1'b0);
      cyc(1'b1, 2'd3, 32'h00FF_F5A5, 1'b0, 1'b0);
      rd(2'd1, 32'h0012_3402, "R2 start address readback");
      rd(2'd2, 32'h00AB_CDE0, "R2 data pointer readback");
      rd(2'd3, 32'h0000_05A5, "R2 xfer ctl readback");
      push("R2 dptr port", SEL_DPTR, 32'h00AB_CDE0);
      fire();

      // R4 R5 launch: run + ie, ack/srst bits clear
      cyc(1'b1, 2'd0, 32'h0000_0005, 1'b0, 1'b0);
      push("R4 fetch_req on launch", SEL_FETCH, 1);
      push("R4 fetch_addr", SEL_FADDR, 32'h0012_3402);
      push("R5 clk_en on", SEL_CLKEN, 1);
      fire();
      rd(2'd0, 32'h5, "R3 status while running");
      idle();
      push("R4 fetch_req single cycle", SEL_FETCH, 0);
      fire();
      // rewrite run=1 while running: no new request
      cyc(1'b1, 2'd0, 32'h0000_0005, 1'b0, 1'b0);
      push("R4 no request when already running", SEL_FETCH, 0);
      fire();

      // R6 frozen pointers while running, transfer control still writable
      cyc(1'b1, 2'd1, 32'h0000_0777, 1'b0, 1'b0);
      cyc(1'b1, 2'd2, 32'h0000_0888, 1'b0, 1'b0);
      cyc(1'b1, 2'd3, 32'h0000_0003, 1'b0, 1'b0);
      rd(2'd1, 32'h0012_3402, "R6 start address ignored while running");
      rd(2'd2, 32'h00AB_CDE0, "R6 data pointer ignored while running");
      rd(2'd3, 32'h0000_0003, "R6 xfer ctl writable while running");

      // R7 R8 engine completion
      cyc(1'b0, 2'd0, 32'd0, 1'b1, 1'b1);
      push("R5 clk_en off after engine clear", SEL_CLKEN, 0);
      push("R8 irq lags done", SEL_IRQ, 0);
      fire();
      rd(2'd0, 32'h6, "R7 status after completion");
      idle();
      push("R8 irq asserted", SEL_IRQ, 1);
      fire();

      // R9 write with ack=0 and done=0 keeps done
      cyc(1'b1, 2'd0, 32'h0000_0004, 1'b0, 1'b0);
      rd(2'd0, 32'h6, "R9 ack=0 no effect");
      push("R9 irq held", SEL_IRQ, 1);
      fire();
      // ack clears
      cyc(1'b1, 2'd0, 32'h0000_000C, 1'b0, 1'b0);
      rd(2'd0, 32'h4, "R9 ack clears done, ack reads 0");
      idle();
      push("R8 irq dropped after ack", SEL_IRQ, 0);
      fire();

      // R10 engine set wins over ack
      cyc(1'b1, 2'd0, 32'h0000_000C, 1'b0, 1'b1);
      rd(2'd0, 32'h6, "R10 engine done beats ack");
      cyc(1'b1, 2'd0, 32'h0000_000C, 1'b0, 1'b0);

      // R11 host forces done
      cyc(1'b1, 2'd0, 32'h0000_0006, 1'b0, 1'b0);
      idle();
      push("R11 forced irq", SEL_IRQ, 1);
      fire();
      // R8 interrupt masked by ie=0
      cyc(1'b1, 2'd0, 32'h0000_0000, 1'b0, 1'b0);
      idle();
      push("R8 irq masked by ie", SEL_IRQ, 0);
      fire();
      rd(2'd0, 32'h2, "R8 done kept while masked");
      cyc(1'b1, 2'd0, 32'h0000_0008, 1'b0, 1'b0);

      // R12 soft reset
      cyc(1'b1, 2'd0, 32'h0000_0001, 1'b0, 1'b0);
      cyc(1'b1, 2'd0, 32'h0000_0010, 1'b0, 1'b0);
      push("R12 soft_rst pulse", SEL_SRST, 1);
      push("R12 clk_en off by soft reset", SEL_CLKEN, 0);
      fire();
      idle();
      push("R12 soft_rst one cycle", SEL_SRST, 0);
      fire();
      cyc(1'b1, 2'd0, 32'h0000_0011, 1'b0, 1'b0);
      push("R12 no pulse with run=1", SEL_SRST, 0);
      push("R4 launch alongside reset bit", SEL_FETCH, 1);
      fire();

      // R7 collisions: running, engine clear beats host run=1
      cyc(1'b1, 2'd0, 32'h0000_0001, 1'b1, 1'b0);
      push("R7 engine clear wins when running", SEL_CLKEN, 0);
      fire();
      // idle: host start wins over engine clear
      cyc(1'b1, 2'd0, 32'h0000_0001, 1'b1, 1'b0);
      push("R7 host start wins when idle", SEL_CLKEN, 1);
      push("R4 fetch on collision start", SEL_FETCH, 1);
      fire();
      // host stop by writing 0
      cyc(1'b1, 2'd0, 32'h0000_0000, 1'b0, 1'b0);
      push("R5 host write 0 stops", SEL_CLKEN, 0);
      fire();

      // R1 hardware reset mid-run
      cyc(1'b1, 2'd0, 32'h0000_0007, 1'b0, 1'b0);
      @(negedge clk); rst_n = 1'b0; #0.5;
      rd(2'd0, 32'd0, "R1 status cleared by reset");
      rd(2'd1, 32'd0, "R1 start address cleared");
      rd(2'd2, 32'd0, "R1 data pointer cleared");
      rd(2'd3, 32'd0, "R1 xfer ctl cleared");
      push("R1 clk_en cleared", SEL_CLKEN, 0);
      push("R1 irq cleared", SEL_IRQ, 0);
      fire();
      @(negedge clk); rst_n = 1'b1;
      idle();

      if (q.size() != 0) begin
         n_fail++;
         $display("FAIL monitor left items actual=%0d expected=0", q.size());
      end
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule